// File: doc/BRIEF.md
# Multiport Flip-Flop Register File

This block is a small memory array built only from flip-flops and multiplexers. It holds `SIZE` words of `WIDTH` bits and has `NWR` write ports and `NRD` read ports. Every write port carries an address, a data word and a per-bit mask, and all of them update the array on one shared write clock. When several write ports hit the same word in one cycle, their masked updates are applied in port-index order, so the highest-numbered port decides each bit it enables.

Each read port is given one of three modes when the block is elaborated. A combinational port returns the addressed word at once. An address-registered port captures its address on its own read clock and then reads the array combinationally, so a write on the same edge is visible. A data-registered port captures the read word itself, so it returns the contents from before that edge's write. Every read port has its own clock and clock polarity. Read-side registers have an asynchronous active-low reset. The storage words have no reset.

Top module: `regmem_ff`

## Requirements
- R1: A write changes storage only at the active edge of `wr_clk`. Before that edge, a combinational read of the target word still returns the old value.
- R2: Bit b of write port p's mask (`wr_mask[p*WIDTH+b]`) decides whether data bit b is written. Bits whose mask bit is clear keep their stored value.
- R3: When several write ports address the same word in one cycle, the masked writes are applied in ascending port order, so for each bit the highest-numbered port with its mask bit set wins.
- R4: A read port in mode 0 (combinational) returns the word at its current `rd_addr` field in the same cycle. After a write edge it shows the new contents.
- R5: A read port in mode 1 registers its address on its read clock edge and reads the array from the registered address. Data written on that same edge is returned.
- R6: A read port in mode 2 registers the read word on its read clock edge. It returns the contents from before any write on that edge.
- R7: A write whose address is `SIZE` or above changes no word.
- R8: A read of an address at `SIZE` or above returns zero, in every mode.
- R9: While `rst_n` is low, a mode-2 port outputs zero and a mode-1 port reads word 0. Stored words are not cleared by reset.
- R10: A cycle in which all write masks are zero leaves every word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Common clock for all write ports (active edge set by `WR_POL`) |
| rst_n | input | 1 | Asynchronous active-low reset for the read-side registers |
| wr_addr | input | NWR*ABITS | Write addresses; port p uses bits [p*ABITS +: ABITS] |
| wr_data | input | NWR*WIDTH | Write data; port p uses bits [p*WIDTH +: WIDTH] |
| wr_mask | input | NWR*WIDTH | Per-bit write enables; port p uses bits [p*WIDTH +: WIDTH] |
| rd_clk | input | NRD | Read clock for each port; the active edge per port is set by `RD_POL` |
| rd_addr | input | NRD*ABITS | Read addresses; port p uses bits [p*ABITS +: ABITS] |
| rd_data | output | NRD*WIDTH | Read data; port p drives bits [p*WIDTH +: WIDTH] |

## Verification
The bench builds the block with 12 words of 8 bits and 4 address bits. That leaves four address codes past the last word, which exercises both the ignored-write and the zero-read behaviour. It uses three write ports, so three-way collisions on one word with overlapping masks can occur, and it uses three read ports, one in each mode. All clocks come from one source. A single write edge can therefore be compared across the combinational, address-registered and data-registered views of the same array in the same cycle.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
  typedef enum logic [1:0] {
    RD_COMB     = 2'd0,
    RD_ADDR_REG = 2'd1,
    RD_DATA_REG = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/regmem_word.sv
// One storage word, updated by all write ports in ascending priority.
module regmem_word #(
  parameter int WIDTH = 8,
  parameter int ABITS = 4,
  parameter int NWR   = 2,
  parameter int INDEX = 0,
  parameter bit WR_POL = 1'b1
) (
  input  logic                   wr_clk,
  input  logic [NWR*ABITS-1:0]   wr_addr,
  input  logic [NWR*WIDTH-1:0]   wr_data,
  input  logic [NWR*WIDTH-1:0]   wr_mask,
  output logic [WIDTH-1:0]       q
);
  localparam logic [ABITS-1:0] MY_ADDR = ABITS'(INDEX);

  logic             wclk;
  logic [WIDTH-1:0] nxt;
  logic             hit;

  assign wclk = WR_POL ? wr_clk : ~wr_clk;

  // next state: later ports overwrite earlier ones bit by bit
  always_comb begin
    nxt = q;
    hit = 1'b0;
    for (int p = 0; p < NWR; p++) begin
      if (wr_addr[p*ABITS +: ABITS] == MY_ADDR) begin
        nxt = (nxt & ~wr_mask[p*WIDTH +: WIDTH]) |
              (wr_data[p*WIDTH +: WIDTH] & wr_mask[p*WIDTH +: WIDTH]);
        hit = hit | (|wr_mask[p*WIDTH +: WIDTH]);
      end
    end
  end

  // storage register, no reset, explicit clock enable
  always_ff @(posedge wclk) begin
    if (hit) q <= nxt;
  end
endmodule

// File: rtl/regmem_rd_tree.sv
// Binary read mux tree; the address MSB steers the root.
module regmem_rd_tree #(
  parameter int WIDTH = 8,
  parameter int ABITS = 4,
  parameter int SIZE  = 12
) (
  input  logic [SIZE*WIDTH-1:0] words,
  input  logic [ABITS-1:0]      addr,
  output logic [WIDTH-1:0]      data
);
  localparam int LEAVES = 1 << ABITS;

  always_comb begin : tree_b
    logic [WIDTH-1:0] cur [LEAVES];
    for (int i = 0; i < SIZE; i++) cur[i] = words[i*WIDTH +: WIDTH];
    for (int i = SIZE; i < LEAVES; i++) cur[i] = '0;
    for (int lev = 0; lev < ABITS; lev++) begin
      for (int k = 0; k < (LEAVES >> (lev + 1)); k++) begin
        cur[k] = addr[lev] ? cur[2*k+1] : cur[2*k];
      end
    end
    data = cur[0];
  end
endmodule

// File: rtl/regmem_rd_port.sv
// One read port; MODE picks where the register sits.
module regmem_rd_port
  import regmem_pkg::*;
#(
  parameter int   WIDTH = 8,
  parameter int   ABITS = 4,
  parameter int   SIZE  = 12,
  parameter logic [1:0] MODE = RD_COMB,
  parameter bit   POL   = 1'b1
) (
  input  logic                  rd_clk,
  input  logic                  rst_n,
  input  logic [SIZE*WIDTH-1:0] words,
  input  logic [ABITS-1:0]      addr,
  output logic [WIDTH-1:0]      data
);
  logic             rclk;
  logic [WIDTH-1:0] tree_out;

  assign rclk = POL ? rd_clk : ~rd_clk;

  generate
    if (MODE == RD_ADDR_REG) begin : g_addr_reg
      logic [ABITS-1:0] addr_q, addr_d;
      assign addr_d = addr;
      always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
      end
      regmem_rd_tree #(.WIDTH(WIDTH), .ABITS(ABITS), .SIZE(SIZE)) u_tree (
        .words(words), .addr(addr_q), .data(tree_out));
      assign data = tree_out;
    end else if (MODE == RD_DATA_REG) begin : g_data_reg
      logic [WIDTH-1:0] data_q;
      regmem_rd_tree #(.WIDTH(WIDTH), .ABITS(ABITS), .SIZE(SIZE)) u_tree (
        .words(words), .addr(addr), .data(tree_out));
      always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= tree_out;
      end
      assign data = data_q;
    end else begin : g_comb
      logic unused_comb;
      assign unused_comb = rclk ^ rst_n;
      regmem_rd_tree #(.WIDTH(WIDTH), .ABITS(ABITS), .SIZE(SIZE)) u_tree (
        .words(words), .addr(addr), .data(tree_out));
      assign data = tree_out;
    end
  endgenerate
endmodule

// File: rtl/regmem_ff.sv
module regmem_ff #(
  parameter int SIZE  = 12,
  parameter int WIDTH = 8,
  parameter int ABITS = 4,
  parameter int NWR   = 2,
  parameter int NRD   = 3,
  parameter logic [2*NRD-1:0] RD_MODE = 6'b10_01_00,
  parameter logic [NRD-1:0]   RD_POL  = {NRD{1'b1}},
  parameter bit WR_POL = 1'b1
) (
  input  logic                 wr_clk,
  input  logic                 rst_n,
  input  logic [NWR*ABITS-1:0] wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_data,
  input  logic [NWR*WIDTH-1:0] wr_mask,
  input  logic [NRD-1:0]       rd_clk,
  input  logic [NRD*ABITS-1:0] rd_addr,
  output logic [NRD*WIDTH-1:0] rd_data
);
  logic [SIZE*WIDTH-1:0] mem_flat;

  generate
    for (genvar i = 0; i < SIZE; i++) begin : g_word
      regmem_word #(
        .WIDTH(WIDTH), .ABITS(ABITS), .NWR(NWR), .INDEX(i), .WR_POL(WR_POL)
      ) u_word (
        .wr_clk (wr_clk),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .wr_mask(wr_mask),
        .q      (mem_flat[i*WIDTH +: WIDTH])
      );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
      regmem_rd_port #(
        .WIDTH(WIDTH), .ABITS(ABITS), .SIZE(SIZE),
        .MODE(RD_MODE[2*p +: 2]), .POL(RD_POL[p])
      ) u_port (
        .rd_clk(rd_clk[p]),
        .rst_n (rst_n),
        .words (mem_flat),
        .addr  (rd_addr[p*ABITS +: ABITS]),
        .data  (rd_data[p*WIDTH +: WIDTH])
      );
    end
  endgenerate
endmodule

// File: rtl/regmem_ff_chk.sv
module regmem_ff_chk #(
  parameter int SIZE  = 12,
  parameter int WIDTH = 8,
  parameter int ABITS = 4,
  parameter int NWR   = 2,
  parameter int NRD   = 3,
  parameter logic [2*NRD-1:0] RD_MODE = 6'b10_01_00,
  parameter logic [NRD-1:0]   RD_POL  = {NRD{1'b1}},
  parameter bit WR_POL = 1'b1
) (
  input logic                 wr_clk,
  input logic                 rst_n,
  input logic [NWR*WIDTH-1:0] wr_mask,
  input logic [NRD-1:0]       rd_clk,
  input logic [NRD*ABITS-1:0] rd_addr,
  input logic [NRD*WIDTH-1:0] rd_data
);
  logic unused_chk;
  assign unused_chk = ^rd_clk;

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_p
      localparam logic [1:0] M = RD_MODE[2*p +: 2];
      if (M == 2'd0 && WR_POL) begin : g_comb
        logic live;
        always_ff @(posedge wr_clk or negedge rst_n) begin
          if (!rst_n) live <= 1'b0;
          else        live <= 1'b1;
        end
        // R8
        rng_zero_comb_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
          (rd_addr[p*ABITS +: ABITS] >= ABITS'(SIZE)) |-> (rd_data[p*WIDTH +: WIDTH] == '0));
        // R10
        idle_hold_comb_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
          (live && $stable(rd_addr[p*ABITS +: ABITS]) && ($past(wr_mask) == '0))
          |-> $stable(rd_data[p*WIDTH +: WIDTH]));
      end else if (M != 2'd0 && RD_POL[p]) begin : g_reg
        logic [1:0] live;
        always_ff @(posedge rd_clk[p] or negedge rst_n) begin
          if (!rst_n)             live <= 2'd0;
          else if (live != 2'd3)  live <= live + 2'd1;
        end
        // R8
        rng_zero_reg_chk: assert property (@(posedge rd_clk[p]) disable iff (!rst_n)
          ((live != 2'd0) && ($past(rd_addr[p*ABITS +: ABITS]) >= ABITS'(SIZE)))
          |-> (rd_data[p*WIDTH +: WIDTH] == '0));
        if (M == 2'd2) begin : g_dreg
          // R6
          idle_hold_dreg_chk: assert property (@(posedge rd_clk[p]) disable iff (!rst_n)
            ((live == 2'd3) && ($past(rd_addr[p*ABITS +: ABITS]) == $past(rd_addr[p*ABITS +: ABITS], 2))
             && ($past(wr_mask, 2) == '0))
            |-> $stable(rd_data[p*WIDTH +: WIDTH]));
        end else begin : g_areg
          // R5
          idle_hold_areg_chk: assert property (@(posedge rd_clk[p]) disable iff (!rst_n)
            ((live == 2'd3) && ($past(rd_addr[p*ABITS +: ABITS]) == $past(rd_addr[p*ABITS +: ABITS], 2))
             && ($past(wr_mask) == '0))
            |-> $stable(rd_data[p*WIDTH +: WIDTH]));
        end
      end
    end
  endgenerate
endmodule

bind regmem_ff regmem_ff_chk #(
  .SIZE(SIZE), .WIDTH(WIDTH), .ABITS(ABITS), .NWR(NWR), .NRD(NRD),
  .RD_MODE(RD_MODE), .RD_POL(RD_POL), .WR_POL(WR_POL)
) u_chk (
  .wr_clk (wr_clk),
  .rst_n  (rst_n),
  .wr_mask(wr_mask),
  .rd_clk (rd_clk),
  .rd_addr(rd_addr),
  .rd_data(rd_data)
);

// File: tb/regmem_ff_bench.sv
`timescale 1ns/1ps
module regmem_ff_bench;
  localparam int SIZE = 12, WIDTH = 8, ABITS = 4, NWR = 3, NRD = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NWR*ABITS-1:0] wr_addr;
  logic [NWR*WIDTH-1:0] wr_data, wr_mask;
  logic [NRD*ABITS-1:0] rd_addr;
  logic [NRD*WIDTH-1:0] rd_data;

  logic [ABITS-1:0] w_addr [NWR];
  logic [WIDTH-1:0] w_data [NWR];
  logic [WIDTH-1:0] w_mask [NWR];
  logic [ABITS-1:0] r_addr [NRD];
  logic [WIDTH-1:0] model  [SIZE];

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NWR; p++) begin
      wr_addr[p*ABITS +: ABITS] = w_addr[p];
      wr_data[p*WIDTH +: WIDTH] = w_data[p];
      wr_mask[p*WIDTH +: WIDTH] = w_mask[p];
    end
    for (int p = 0; p < NRD; p++) rd_addr[p*ABITS +: ABITS] = r_addr[p];
  end

  regmem_ff #(
    .SIZE(SIZE), .WIDTH(WIDTH), .ABITS(ABITS), .NWR(NWR), .NRD(NRD),
    .RD_MODE(6'b10_01_00), .RD_POL(3'b111), .WR_POL(1'b1)
  ) u_regmem_ff (
    .wr_clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_clk({NRD{clk}}), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [WIDTH-1:0] ref_rd(input logic [ABITS-1:0] a);
    return (a < SIZE) ? model[a] : '0;
  endfunction

  function automatic logic [WIDTH-1:0] port_out(input int p);
    return rd_data[p*WIDTH +: WIDTH];
  endfunction

  task automatic ref_write();
    for (int p = 0; p < NWR; p++)
      if (w_addr[p] < SIZE)
        model[w_addr[p]] = (model[w_addr[p]] & ~w_mask[p]) | (w_data[p] & w_mask[p]);
  endtask

  task automatic chk(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic no_writes();
    for (int p = 0; p < NWR; p++) begin
      w_mask[p] = '0; w_addr[p] = '0; w_data[p] = '0;
    end
  endtask

  // one write edge; checks the three read modes afterwards at negedge
  task automatic cycle(input bit do_chk);
    logic [WIDTH-1:0] pre2;
    pre2 = ref_rd(r_addr[2]);
    @(posedge clk);
    ref_write();
    @(negedge clk);
    if (do_chk) begin
      chk("R4 comb read", port_out(0), ref_rd(r_addr[0]));
      chk("R5 addr-registered read", port_out(1), ref_rd(r_addr[1]));
      chk("R6 data-registered read", port_out(2), pre2);
    end
  endtask

  task automatic scan(input string tag);
    no_writes();
    for (int i = 0; i < SIZE; i++) begin
      r_addr[0] = ABITS'(i);
      #1;
      chk(tag, port_out(0), model[i]);
      cycle(1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    no_writes();
    for (int p = 0; p < NRD; p++) r_addr[p] = 4'd2;
    repeat (3) @(negedge clk);
    // R9: data-registered port is zero in reset
    chk("R9 reset data-registered", port_out(2), '0);
    rst_n = 1'b1;

    // fill every word through port 0
    for (int i = 0; i < SIZE; i++) begin
      no_writes();
      w_addr[0] = ABITS'(i); w_data[0] = WIDTH'(8'h30 + i); w_mask[0] = '1;
      cycle(1'b0);
    end
    scan("R4 fill readback");

    // R1: before the edge the old value shows on the comb port
    no_writes();
    w_addr[0] = 4'd5; w_data[0] = 8'hC5; w_mask[0] = '1;
    r_addr[0] = 4'd5; r_addr[1] = 4'd5; r_addr[2] = 4'd5;
    #1;
    chk("R1 pre-edge comb", port_out(0), model[5]);
    cycle(1'b1);
    chk("R1 post-edge comb", port_out(0), 8'hC5);

    // R2: partial mask
    no_writes();
    w_addr[1] = 4'd3; w_data[1] = 8'hAB; w_mask[1] = 8'h0F;
    r_addr[0] = 4'd3; r_addr[1] = 4'd3; r_addr[2] = 4'd3;
    cycle(1'b1);
    chk("R2 masked bits", port_out(0), 8'h3B);

    // R3: three ports collide on word 6
    w_addr[0] = 4'd6; w_data[0] = 8'h11; w_mask[0] = 8'hFF;
    w_addr[1] = 4'd6; w_data[1] = 8'h22; w_mask[1] = 8'hFF;
    w_addr[2] = 4'd6; w_data[2] = 8'h33; w_mask[2] = 8'h0F;
    r_addr[0] = 4'd6; r_addr[1] = 4'd6; r_addr[2] = 4'd6;
    cycle(1'b1);
    chk("R3 port priority", port_out(1), 8'h23);
    chk("R6 old value under collision", port_out(2), 8'h36);

    // R7: out-of-range write
    no_writes();
    w_addr[0] = 4'd13; w_data[0] = 8'hFF; w_mask[0] = '1;
    w_addr[2] = 4'd15; w_data[2] = 8'h00; w_mask[2] = '1;
    cycle(1'b0);
    scan("R7 out-of-range write ignored");

    // R8: out-of-range read in all modes
    r_addr[0] = 4'd12; r_addr[1] = 4'd14; r_addr[2] = 4'd15;
    cycle(1'b0);
    chk("R8 comb zero", port_out(0), '0);
    chk("R8 addr-registered zero", port_out(1), '0);
    chk("R8 data-registered zero", port_out(2), '0);

    // R10: data driven, masks all zero
    for (int p = 0; p < NWR; p++) begin
      w_addr[p] = ABITS'(p + 7); w_data[p] = 8'h5A; w_mask[p] = '0;
    end
    cycle(1'b0);
    scan("R10 zero mask keeps storage");

    // R9: mid-run reset keeps storage
    r_addr[0] = 4'd6; r_addr[1] = 4'd9; r_addr[2] = 4'd4;
    cycle(1'b0);
    rst_n = 1'b0;
    #1;
    chk("R9 reset data-registered", port_out(2), '0);
    chk("R9 reset addr-registered word0", port_out(1), model[0]);
    chk("R9 storage kept", port_out(0), model[6]);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b0);

    // random traffic with collisions
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NWR; p++) begin
        w_addr[p] = ($urandom % 4 == 0) ? 4'd3 : ABITS'($urandom % 16);
        w_data[p] = WIDTH'($urandom);
        w_mask[p] = ($urandom % 3 == 0) ? '0 : WIDTH'($urandom);
      end
      for (int p = 0; p < NRD; p++)
        r_addr[p] = ($urandom % 4 == 0) ? 4'd3 : ABITS'($urandom % 16);
      cycle(1'b1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule